// File: doc/BRIEF.md
# Multiplexed-Address Flash Program Sequencer

This block is the command front end of a byte-wide flash device whose address arrives in two halves over one shared bus. The host drives the low half of the address and lowers the row/column strobe, then drives the high half and raises the strobe. Each write completes when the active-low write enable returns high. At that point the data byte is taken together with the address assembled from the two halves. All strobes are sampled on a system clock, and their edges are found by comparing each strobe with its value one clock earlier.

A byte program needs three unlock writes before it. The fourth write carries the target address and the data. The block then holds an internal busy state for a fixed number of clocks. During that time a read returns polling status in place of array contents, and any write is dropped. When the busy time ends, the byte is merged into a small array model. A bit can only go from 1 to 0, so the merge is a bitwise AND with the old value. Pulling the reset pin low abandons any sequence or program in flight and returns the array model to the erased state.

Top module: `mux_flash_prog_seq`

## Requirements
- R1: A falling edge of `rowColN` loads `addrBus` as address bits 10:0, and a rising edge loads `addrBus` as bits 21:11. The array model is indexed by the lowest `ARR_AW` bits of the combined 22-bit address, so 000805h and 000005h name the same byte.
- R2: A write happens on the clock where `weN` is seen rising. It takes `dataIn` at that clock and the address last assembled.
- R3: The writes 005555h/AAh, 002AAAh/55h and 005555h/A0h, in that order, arm a program. The next write starts programming its own address with its own data.
- R4: If any of the three unlock writes has the wrong address or data, the sequencer returns to idle. The writes that follow must begin the whole sequence again, and the array is not changed.
- R5: Busy lasts exactly `PROG_CYCLES` clocks, counted from the clock that takes the fourth write. The byte commits on the last of these clocks, and a read returns true array data from the next cycle on.
- R6: During busy, a read returns bit 7 as the complement of bit 7 of the data being programmed, and bits 5:0 read as zero.
- R7: During busy, bit 6 of a read inverts at each falling edge of `oeN`, so two reads in a row differ in bit 6.
- R8: A write during busy is ignored. This includes a complete unlock-and-program sequence.
- R9: Programming stores the old byte ANDed with the new data.
- R10: While `oeN` is high, `dataOutEn` is low and `dataOut` is 00h. While `oeN` is low, `dataOutEn` is high and `dataOut` shows the addressed byte when the block is not busy.
- R11: While `rstN` is low, the sequencer returns to idle and drops any program in flight. Afterwards every byte of the array model reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all strobes are sampled |
| rstN | input | 1 | Active-low reset; aborts sequences and erases the array model |
| addrBus | input | ROW_W | Shared address bus carrying the row half, then the column half |
| rowColN | input | 1 | Row/column strobe; falling edge loads the row, rising edge loads the column |
| weN | input | 1 | Active-low write enable; rising edge completes a write |
| oeN | input | 1 | Active-low output enable |
| dataIn | input | 8 | Write data and command byte |
| dataOut | output | 8 | Read data or polling status; 00h when not enabled |
| dataOutEn | output | 1 | High while the block drives read data |

## Verification
The program path is driven with several write patterns: a correct unlock sequence into an erased byte, a second program onto a byte already programmed, and a target address whose column half is non-zero. These show, in order, a plain store, the AND merge, and address folding into the array index. Two broken sequences, one with a wrong data byte and one with a wrong address, show that each key is compared in full before a program can start. Directed runs then hold the output enable low across the fourth write to find the exact clock where polling gives way to data. They also issue back-to-back reads and a full unlock sequence during busy, and they assert reset in the middle of a program.

// File: rtl/mfp_pkg.sv
package mfp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_ARMED,
    ST_BUSY
  } mfpState_t;

  // strobes sent from control to datapath, one clock wide
  typedef struct packed {
    logic captureRow;
    logic captureCol;
    logic startProg;
    logic commitProg;
    logic readPulse;
  } mfpStrobes_t;

  localparam logic [7:0] KEY_DATA_1 = 8'hAA;
  localparam logic [7:0] KEY_DATA_2 = 8'h55;
  localparam logic [7:0] KEY_DATA_3 = 8'hA0;
  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;

endpackage

// File: rtl/mfp_ctrl.sv
module mfp_ctrl
  import mfp_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int PROG_CYCLES = 20,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rowColN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [7:0]        dataIn,
  output mfpStrobes_t       strobes,
  output logic              busy
);

  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(KEY_ADDR_B);

  mfpState_t        state, nextState;
  logic             prevRc, prevWe, prevOe;
  logic             rcFall, rcRise, weRise, oeFall;
  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRc <= 1'b1;
      prevWe <= 1'b1;
      prevOe <= 1'b1;
    end else begin
      prevRc <= rowColN;
      prevWe <= weN;
      prevOe <= oeN;
    end
  end

  assign rcFall = prevRc & ~rowColN;
  assign rcRise = ~prevRc & rowColN;
  assign weRise = ~prevWe & weN;
  assign oeFall = prevOe & ~oeN;

  always_comb begin
    nextState          = state;
    strobes            = '0;
    strobes.captureRow = rcFall;
    strobes.captureCol = rcRise;
    strobes.readPulse  = oeFall;
    unique case (state)
      ST_IDLE:
        if (weRise)
          nextState = (curAddr == ADDR_A && dataIn == KEY_DATA_1) ? ST_KEY1 : ST_IDLE;
      ST_KEY1:
        if (weRise)
          nextState = (curAddr == ADDR_B && dataIn == KEY_DATA_2) ? ST_KEY2 : ST_IDLE;
      ST_KEY2:
        if (weRise)
          nextState = (curAddr == ADDR_A && dataIn == KEY_DATA_3) ? ST_ARMED : ST_IDLE;
      ST_ARMED:
        if (weRise) begin
          strobes.startProg = 1'b1;
          nextState         = ST_BUSY;
        end
      ST_BUSY:
        if (busyCnt == '0) begin
          strobes.commitProg = 1'b1;
          nextState          = ST_IDLE;
        end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busyCnt <= '0;
    end else begin
      state <= nextState;
      if (strobes.startProg)
        busyCnt <= CNT_W'(PROG_CYCLES - 1);
      else if (state == ST_BUSY && busyCnt != '0)
        busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = (state == ST_BUSY);

endmodule

// File: rtl/mfp_datapath.sv
module mfp_datapath
  import mfp_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int ARR_AW = 6,
  localparam int ADDR_W = 2 * ROW_W,
  localparam int DEPTH  = 1 << ARR_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ROW_W-1:0]  addrBus,
  input  logic [7:0]        dataIn,
  input  logic              oeN,
  input  mfpStrobes_t       strobes,
  input  logic              busy,
  output logic [ADDR_W-1:0] curAddr,
  output logic [7:0]        dataOut,
  output logic              dataOutEn
);

  logic [ROW_W-1:0]  rowReg, colReg;
  logic [ARR_AW-1:0] progIdx;
  logic [7:0]        progData;
  logic              toggleBit;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        arrayByte;
  logic [7:0]        readByte;

  assign curAddr = {colReg, rowReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg    <= '0;
      colReg    <= '0;
      progIdx   <= '0;
      progData  <= 8'hFF;
      toggleBit <= 1'b0;
    end else begin
      if (strobes.captureRow) rowReg <= addrBus;
      if (strobes.captureCol) colReg <= addrBus;
      if (strobes.startProg) begin
        progIdx   <= curAddr[ARR_AW-1:0];
        progData  <= dataIn;
        toggleBit <= 1'b0;
      end else if (busy && strobes.readPulse) begin
        toggleBit <= ~toggleBit;
      end
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          mem[g] <= 8'hFF;
        else if (strobes.commitProg && progIdx == ARR_AW'(g))
          mem[g] <= mem[g] & progData;
      end
    end
  endgenerate

  assign arrayByte = mem[curAddr[ARR_AW-1:0]];
  assign readByte  = busy ? {~progData[7], toggleBit, 6'b0} : arrayByte;
  assign dataOutEn = ~oeN;
  assign dataOut   = oeN ? 8'h00 : readByte;

endmodule

// File: rtl/mux_flash_prog_seq.sv
module mux_flash_prog_seq
  import mfp_pkg::*;
#(
  parameter int ROW_W       = 11,
  parameter int ARR_AW      = 6,
  parameter int PROG_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ROW_W-1:0] addrBus,
  input  logic             rowColN,
  input  logic             weN,
  input  logic             oeN,
  input  logic [7:0]       dataIn,
  output logic [7:0]       dataOut,
  output logic             dataOutEn
);

  localparam int ADDR_W = 2 * ROW_W;

  mfpStrobes_t       strobes;
  logic              busy;
  logic [ADDR_W-1:0] curAddr;

  mfp_ctrl #(
    .ADDR_W      (ADDR_W),
    .PROG_CYCLES (PROG_CYCLES)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rowColN (rowColN),
    .weN     (weN),
    .oeN     (oeN),
    .curAddr (curAddr),
    .dataIn  (dataIn),
    .strobes (strobes),
    .busy    (busy)
  );

  mfp_datapath #(
    .ROW_W  (ROW_W),
    .ARR_AW (ARR_AW)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .addrBus   (addrBus),
    .dataIn    (dataIn),
    .oeN       (oeN),
    .strobes   (strobes),
    .busy      (busy),
    .curAddr   (curAddr),
    .dataOut   (dataOut),
    .dataOutEn (dataOutEn)
  );

endmodule

// File: rtl/mfp_checker.sv
module mfp_checker
  import mfp_pkg::*;
#(
  parameter int PROG_CYCLES = 20
) (
  input logic        clk,
  input logic        rstN,
  input logic        oeN,
  input logic [7:0]  dataOut,
  input logic        dataOutEn,
  input logic        busy,
  input mfpStrobes_t strobes
);

  int unsigned busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> (dataOut == 8'h00 && !dataOutEn)); // R10

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyRun < PROG_CYCLES); // R5

  AST_COMMIT_ON_TIME: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitProg |-> busyRun == PROG_CYCLES - 1); // R5

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startProg |=> busy); // R3

  AST_NO_START_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.startProg); // R8

  AST_POLL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !oeN) |-> dataOut[5:0] == 6'b0); // R6

  AST_POLL_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !oeN && $past(!oeN) && $past(!oeN, 2)) |-> $stable(dataOut)); // R7

endmodule

bind mux_flash_prog_seq mfp_checker #(.PROG_CYCLES(PROG_CYCLES)) i_mfp_checker (
  .clk       (clk),
  .rstN      (rstN),
  .oeN       (oeN),
  .dataOut   (dataOut),
  .dataOutEn (dataOutEn),
  .busy      (busy),
  .strobes   (strobes)
);

// File: tb/test_mux_flash_prog_seq.sv
`timescale 1ns/1ps
module test_mux_flash_prog_seq;

  localparam int ROW_W = 11;
  localparam int ARR_AW = 6;
  localparam int PROG = 40;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_P = 2'd2, OP_X = 2'd3;
  localparam int NVEC = 39;

  // {op, 22-bit address, data or expected byte}
  localparam logic [31:0] VEC [NVEC] = '{
    {OP_R, 22'h000003, 8'hFF},
    {OP_W, 22'h005555, 8'hAA}, {OP_W, 22'h002AAA, 8'h55}, {OP_W, 22'h005555, 8'hA0},
    {OP_W, 22'h000003, 8'h5A}, {OP_P, 22'h000003, 8'h5A}, {OP_X, 22'h0, 8'h00},
    {OP_R, 22'h000003, 8'h5A},
    {OP_W, 22'h005555, 8'hAA}, {OP_W, 22'h002AAA, 8'h55}, {OP_W, 22'h005555, 8'hA0},
    {OP_W, 22'h000003, 8'h0F}, {OP_X, 22'h0, 8'h00}, {OP_R, 22'h000003, 8'h0A},
    {OP_W, 22'h005555, 8'hAA}, {OP_W, 22'h002AAA, 8'h55}, {OP_W, 22'h005555, 8'hA0},
    {OP_W, 22'h000805, 8'h81}, {OP_X, 22'h0, 8'h00}, {OP_R, 22'h000005, 8'h81},
    {OP_W, 22'h005555, 8'hAA}, {OP_W, 22'h002AAA, 8'h54}, {OP_W, 22'h005555, 8'hA0},
    {OP_W, 22'h000010, 8'h00}, {OP_X, 22'h0, 8'h00}, {OP_R, 22'h000010, 8'hFF},
    {OP_W, 22'h005555, 8'hAA}, {OP_W, 22'h002AAA, 8'h55}, {OP_W, 22'h005554, 8'hA0},
    {OP_W, 22'h000011, 8'h00}, {OP_X, 22'h0, 8'h00}, {OP_R, 22'h000011, 8'hFF},
    {OP_W, 22'h005555, 8'hAA}, {OP_W, 22'h002AAA, 8'h55}, {OP_W, 22'h005555, 8'hA0},
    {OP_W, 22'h00002C, 8'h3C}, {OP_P, 22'h00002C, 8'h3C}, {OP_X, 22'h0, 8'h00},
    {OP_R, 22'h00002C, 8'h3C}
  };

  // requirement covered by each table entry
  localparam string VREQ [NVEC] = '{
    "R11", "R3", "R3", "R3", "R3", "R6", "R5", "R3",
    "R3", "R3", "R3", "R9", "R5", "R9",
    "R1", "R1", "R1", "R1", "R5", "R1",
    "R4", "R4", "R4", "R4", "R5", "R4",
    "R4", "R4", "R4", "R4", "R5", "R4",
    "R2", "R2", "R2", "R2", "R6", "R5", "R2"
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ROW_W-1:0] addrBus = '0;
  logic rowColN = 1'b1;
  logic weN = 1'b1;
  logic oeN = 1'b1;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOutEn;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  mux_flash_prog_seq #(
    .ROW_W(ROW_W), .ARR_AW(ARR_AW), .PROG_CYCLES(PROG)
  ) i_mux_flash_prog_seq (
    .clk(clk), .rstN(rstN), .addrBus(addrBus), .rowColN(rowColN),
    .weN(weN), .oeN(oeN), .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setAddr(input logic [21:0] a);
    @(negedge clk); addrBus = a[10:0]; rowColN = 1'b0;
    @(negedge clk); addrBus = a[21:11]; rowColN = 1'b1;
  endtask

  task automatic busWrite(input logic [21:0] a, input logic [7:0] d);
    setAddr(a);
    @(negedge clk); weN = 1'b0; dataIn = d;
    @(negedge clk); weN = 1'b1;
  endtask

  task automatic busRead(input logic [21:0] a, output logic [7:0] v);
    setAddr(a);
    @(negedge clk); oeN = 1'b0;
    @(negedge clk); v = dataOut;
    oeN = 1'b1;
  endtask

  task automatic unlockProg(input logic [21:0] a, input logic [7:0] d);
    busWrite(22'h005555, 8'hAA);
    busWrite(22'h002AAA, 8'h55);
    busWrite(22'h005555, 8'hA0);
    busWrite(a, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    // R10 R11: reset state at the ports
    check("R11", {dataOutEn, dataOut}, 9'h000);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R10", {dataOutEn, dataOut}, 9'h000);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][31:30])
        OP_W: busWrite(VEC[i][29:8], VEC[i][7:0]);
        OP_R: begin
          busRead(VEC[i][29:8], v);
          check(VREQ[i], {1'b0, v}, {1'b0, VEC[i][7:0]});
        end
        OP_P: begin
          busRead(VEC[i][29:8], v);
          check(VREQ[i], {1'b0, v & 8'hBF}, {1'b0, ~VEC[i][7], 7'b0});
        end
        default: repeat (PROG + 4) @(negedge clk);
      endcase
    end

    // R5: exact busy length, output enable held low through the fourth write
    busWrite(22'h005555, 8'hAA);
    busWrite(22'h002AAA, 8'h55);
    busWrite(22'h005555, 8'hA0);
    setAddr(22'h000030);
    @(negedge clk); oeN = 1'b0; weN = 1'b0; dataIn = 8'h7E;
    @(negedge clk); weN = 1'b1;
    @(posedge clk);
    repeat (PROG - 1) @(posedge clk);
    @(negedge clk);
    check("R5", {dataOutEn, dataOut & 8'hBF}, 9'h180);
    @(negedge clk);
    check("R5", {dataOutEn, dataOut}, 9'h17E);
    oeN = 1'b1;
    @(negedge clk);
    check("R10", {dataOutEn, dataOut}, 9'h000);

    // R7 R8: toggling between reads and a full sequence ignored while busy
    unlockProg(22'h000020, 8'h11);
    busRead(22'h000020, v);
    busRead(22'h000020, v2);
    check("R7", {1'b0, v[6] ^ v2[6]}, 9'h001);
    check("R6", {1'b0, v2 & 8'hBF}, 9'h080);
    unlockProg(22'h000012, 8'h00);
    repeat (PROG + 4) @(negedge clk);
    busRead(22'h000020, v);
    check("R9", {1'b0, v}, 9'h011);
    busRead(22'h000012, v);
    check("R8", {1'b0, v}, 9'h0FF);

    // R11: reset in the middle of a program
    unlockProg(22'h000003, 8'h00);
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", {dataOutEn, dataOut}, 9'h000);
    rstN = 1'b1;
    repeat (PROG + 4) @(negedge clk);
    busRead(22'h000003, v);
    check("R11", {1'b0, v}, 9'h0FF);
    busRead(22'h000020, v);
    check("R11", {1'b0, v}, 9'h0FF);
    // after reset a new sequence works from idle
    unlockProg(22'h000001, 8'hC3);
    repeat (PROG + 4) @(negedge clk);
    busRead(22'h000001, v);
    check("R3", {1'b0, v}, 9'h0C3);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule